// File: doc/BRIEF.md
# Wait-for-Interrupt Standby Controller

This block parks a processor core in a low-power idle state after a wait-for-interrupt request and wakes it when the core has to run again. After the one-cycle request strobe, it holds off new interface accesses. It then waits until the write buffer is empty and every external interface reports idle. Only then does it raise the standby indication and drop the core clock-enable. That clock-enable drives an integrated clock-gate cell outside this block. System logic can also use the standby indication to stop clocks to other units that are idle, such as an external coprocessor.

The wake logic runs on a clock that is never gated, so it still sees wake sources while the core clock is stopped. There are four wake sources: an active-low IRQ, an active-low FIQ, an external debug request pin and a debug-control request bit. All four are level-sensitive. When a wake source is seen at a clock edge during standby, the standby indication stays high for one more cycle and then falls. The clock-enable returns in that same cycle, and the access grant follows one cycle later. If a wake source is already active while the controller is still waiting to go quiet, the entry is cancelled and standby is never raised.

Top module: `wfi_standby_ctrl`

## Requirements
- R1: While reset is held and right after it is released, standby is 0, core_clk_en is 1 and access_grant is 1.
- R2: After a wfi_req seen at an edge in the running state, access_grant is 0 from the next cycle on. Standby stays 0 for as long as wbuf_empty is 0.
- R3: Standby rises only in the cycle after an edge at which wbuf_empty and all bits of if_idle were 1. The bits of if_idle are: bit 0 for the bus, bit 1 for tightly coupled memory, bit 2 for the coprocessor.
- R4: core_clk_en is 0 in exactly the cycles in which standby is 1.
- R5: Each of the four wake sources, on its own, ends standby: irq_n low, fiq_n low, ext_dbg_req high, and dbg_ctl_req high.
- R6: When a wake source is active at an edge during standby, standby stays 1 in the next cycle and is 0 in the cycle after that.
- R7: access_grant is 0 whenever standby is 1. It returns to 1 one cycle after standby falls.
- R8: A wake source that is active at an edge while entry is pending returns the block to running. Standby is not raised, and access_grant is 1 in the next cycle.
- R9: wfi_req has no effect while entry is pending or while in standby. Standby stays 1 for as long as no wake source is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, never gated |
| rst_n | input | 1 | Active-low synchronous reset |
| wfi_req | input | 1 | One-cycle wait-for-interrupt request strobe |
| wbuf_empty | input | 1 | Write buffer has drained |
| if_idle | input | N_IF | Per-interface idle flags (0 bus, 1 TCM, 2 coprocessor) |
| irq_n | input | 1 | Normal interrupt, active low, level |
| fiq_n | input | 1 | Fast interrupt, active low, level |
| ext_dbg_req | input | 1 | External debug request pin |
| dbg_ctl_req | input | 1 | Debug request bit from the debug control register |
| standby | output | 1 | Core is in standby; all interfaces idle |
| core_clk_en | output | 1 | Enable for the core clock gate |
| access_grant | output | 1 | Interfaces may start new accesses |

## Verification
The bench builds the block with the default N_IF of 3, so there is one idle flag each for the bus, TCM and coprocessor ports. With this width the bench can clear each flag on its own while the write buffer is empty and show that any single busy interface holds off standby. It can also run every wake source through the exact two-cycle exit and the grant that follows, and inject wakes during the drain phase to exercise the cancel path.

// File: rtl/wfi_standby_ctrl.sv
module wfi_standby_ctrl #(
  parameter int N_IF = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wfi_req,
  input  logic            wbuf_empty,
  input  logic [N_IF-1:0] if_idle,
  input  logic            irq_n,
  input  logic            fiq_n,
  input  logic            ext_dbg_req,
  input  logic            dbg_ctl_req,
  output logic            standby,
  output logic            core_clk_en,
  output logic            access_grant
);

  typedef enum logic [1:0] {S_RUN, S_DRAIN, S_STBY, S_WAKE} st_t;

  st_t  st, st_nx;
  logic wake_any, quiet, parked_nx;

  assign wake_any  = !irq_n || !fiq_n || ext_dbg_req || dbg_ctl_req;
  assign quiet     = wbuf_empty && (&if_idle);
  assign parked_nx = (st_nx == S_STBY) || (st_nx == S_WAKE);

  always_comb begin
    st_nx = st;
    case (st)
      S_RUN:   if (wfi_req) st_nx = S_DRAIN;
      S_DRAIN: if (wake_any) st_nx = S_RUN;
               else if (quiet) st_nx = S_STBY;
      S_STBY:  if (wake_any) st_nx = S_WAKE;
      S_WAKE:  st_nx = S_RUN;
      default: st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_RUN;
      standby      <= 1'b0;
      core_clk_en  <= 1'b1;
      access_grant <= 1'b1;
    end else begin
      st           <= st_nx;
      standby      <= parked_nx;
      core_clk_en  <= !parked_nx;
      access_grant <= (st_nx == S_RUN) && (st != S_WAKE);
    end
  end

endmodule

module wfi_standby_ctrl_chk #(
  parameter int N_IF = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wfi_req,
  input logic            wbuf_empty,
  input logic [N_IF-1:0] if_idle,
  input logic            irq_n,
  input logic            fiq_n,
  input logic            ext_dbg_req,
  input logic            dbg_ctl_req,
  input logic            standby,
  input logic            core_clk_en,
  input logic            access_grant
);
  logic wake;
  assign wake = !irq_n || !fiq_n || ext_dbg_req || dbg_ctl_req;

  p_entry_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> $past(wbuf_empty));

  p_entry_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> $past(&if_idle));

  p_clk_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> standby);

  p_exit_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby) |-> $past(wake, 2) && core_clk_en);

  p_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !access_grant);

  p_grant_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby) && !wfi_req |=> access_grant);

  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !standby && wake |=> !standby);
endmodule

bind wfi_standby_ctrl wfi_standby_ctrl_chk #(.N_IF(N_IF)) u_chk (.*);

// File: tb/wfi_standby_ctrl_tb.sv
module wfi_standby_ctrl_tb;
  localparam int N_IF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_req = 1'b0, wbuf_empty = 1'b1;
  logic [N_IF-1:0] if_idle = '1;
  logic irq_n = 1'b1, fiq_n = 1'b1, ext_dbg_req = 1'b0, dbg_ctl_req = 1'b0;
  logic standby, core_clk_en, access_grant;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  wfi_standby_ctrl #(.N_IF(N_IF)) u_dut (.*);

  task automatic cmp(input logic [2:0] exp, input string tag);
    logic [2:0] act;
    act = {standby, core_clk_en, access_grant};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {standby,clk_en,grant} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp(it.exp, it.tag);
    end
  end

  task automatic step(input logic wfi, input logic wb, input logic [N_IF-1:0] idl,
                      input logic [3:0] wk, input logic [2:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    wfi_req = wfi; wbuf_empty = wb; if_idle = idl;
    irq_n = !wk[0]; fiq_n = !wk[1]; ext_dbg_req = wk[2]; dbg_ctl_req = wk[3];
    it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  localparam logic [2:0] RUN = 3'b011, HOLD = 3'b010, PARK = 3'b100;

  task automatic enter_quiet();
    step(1, 1, '1, 4'h0, HOLD, "R2 request drops grant");
    step(0, 1, '1, 4'h0, PARK, "R3 standby after quiet");
  endtask

  task automatic wake_by(input int src, input string tag);
    step(0, 1, '1, 4'(1 << src), PARK, {tag, " R6 standby held one cycle"});
    step(0, 1, '1, 4'h0, HOLD, {tag, " R6 R4 standby low clk on"});
    step(0, 1, '1, 4'h0, RUN, {tag, " R7 grant one cycle later"});
  endtask

  initial begin
    repeat (2) @(negedge clk);
    cmp(RUN, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, '1, 4'h0, RUN, "R1 after reset");

    step(1, 0, '1, 4'h0, HOLD, "R2 enter drain");
    step(0, 0, '1, 4'h0, HOLD, "R2 write buffer busy");
    for (int b = 0; b < N_IF; b++)
      step(0, 1, '1 & ~(N_IF'(1) << b), 4'h0, HOLD, "R3 one interface busy");
    step(1, 0, '1, 4'h0, HOLD, "R9 wfi in drain ignored");
    step(0, 1, '1, 4'h0, PARK, "R3 R4 standby entered");
    step(1, 1, '1, 4'h0, PARK, "R9 wfi in standby ignored");
    step(0, 1, 3'b000, 4'h0, PARK, "R9 standby held without wake");
    wake_by(0, "R5 irq");

    enter_quiet(); wake_by(1, "R5 fiq");
    enter_quiet(); wake_by(2, "R5 ext debug");
    enter_quiet(); wake_by(3, "R5 debug bit");

    step(1, 0, '1, 4'h0, HOLD, "R8 enter drain");
    step(0, 0, '1, 4'h1, RUN, "R8 irq cancels entry");
    step(0, 1, '1, 4'h0, RUN, "R8 no standby after cancel");
    step(1, 1, '1, 4'h4, HOLD, "R8 request with wake pending");
    step(0, 1, '1, 4'h4, RUN, "R8 pending wake cancels");
    step(0, 1, '1, 4'h0, RUN, "R8 stays running");

    enter_quiet();
    step(0, 1, '1, 4'h1, PARK, "R6 held wake");
    step(0, 1, '1, 4'h1, HOLD, "R6 exit with wake still held");
    step(0, 1, '1, 4'h1, RUN, "R7 grant with wake held");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule